// File: doc/BRIEF.md
# Mixed-Decay Current Chopper Sequencer

This block is the digital sequencer for one full bridge under peak-current regulation. While enabled it switches on one diagonal of the bridge, chosen by a direction bit, so that current builds in the winding. It then waits for an external current-sense comparator to report that the trip level has been reached. A blanking window masks the comparator after every switching event, so turn-on transients cannot end the on-phase early.

A trip starts an off-time of fixed length. The off-time has three parts. First comes a fast-decay slice with the opposite diagonal conducting. Then all four gates are held off for a short gap, which guards against shoot-through. Slow decay fills the rest, with both low-side switches on. Conduction during decay is synchronous rectification, and a zero-current flag cuts it so the load current cannot reverse. When the off-time expires, a new on-phase begins and the direction bit is sampled again. All durations are clock-cycle parameters, so one build serves both a 30 µs and an 8.1 µs off-time.

Top module: `mixdecay_chopper`

## Requirements
- R1: Reset, or `en_i` sampled low at a rising edge, puts the block in the coast state (`state_o` = 0) from the next cycle on, with all four gate outputs low.
- R2: `phase_i` is sampled on entry to an on-phase (`state_o` = 1). Value 1 drives `hs_a_o` and `ls_b_o`; value 0 drives `hs_b_o` and `ls_a_o`. The sampled direction holds through that on-phase and the off-time after it, whatever `phase_i` does meanwhile.
- R3: During the first `BLANK_CYC` cycles of an on-phase, `cmp_i` is ignored. From on-phase cycle index `BLANK_CYC` (0-based) a sampled high `cmp_i` ends the on-phase. Without a trip the on-phase lasts indefinitely.
- R4: A trip moves the block to fast decay (`state_o` = 2) in the next cycle. Fast decay lasts round(0.301 × `OFF_CYC`) cycles and drives the opposite diagonal.
- R5: After fast decay, the block holds all gates low for `DEAD_CYC` cycles (`state_o` = 3).
- R6: Slow decay (`state_o` = 4) fills the remaining cycles, so the off-time totals `OFF_CYC` cycles. It drives `ls_a_o` and `ls_b_o`.
- R7: If `zero_i` is sampled high during the off-time, all gates are low from the next cycle until the off-time ends. State timing is unchanged.
- R8: When the off-time ends, a new on-phase begins at once with its blanking window active.
- R9: The high-side and low-side outputs of the same leg are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low forces coast |
| phase_i | input | 1 | Current direction request |
| cmp_i | input | 1 | Current-sense comparator, high at trip level |
| zero_i | input | 1 | Zero-current detect flag |
| hs_a_o | output | 1 | High-side gate enable, leg A |
| hs_b_o | output | 1 | High-side gate enable, leg B |
| ls_a_o | output | 1 | Low-side gate enable, leg A |
| ls_b_o | output | 1 | Low-side gate enable, leg B |
| state_o | output | 3 | Sequencer state: 0 coast, 1 on, 2 fast, 3 gap, 4 slow |

## Verification
Several properties are checked on every cycle:
- leg exclusivity;
- the coast response to a low enable;
- the comparator being masked while blanking runs;
- a trip leading to fast decay;
- fast decay handing over to the gap;
- the gap holding all gates off;
- zero-current cutting the gates;
- the direction holding through decay.

The exact lengths of fast decay, slow decay and the whole off-time, and the choice of diagonal for each phase value, come only from the bench's timed scenarios. The same is true of a comparator pulse swallowed inside the window and the resampling of direction at a new on-phase.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_COAST = 3'd0,
        ST_DRIVE = 3'd1,
        ST_FAST  = 3'd2,
        ST_GAP   = 3'd3,
        ST_SLOW  = 3'd4
    } chop_state_e;

    typedef struct packed {
        chop_state_e state;
        logic        dir;
        logic        rect;
    } chop_regs_t;

    typedef struct packed {
        logic hs_a;
        logic hs_b;
        logic ls_a;
        logic ls_b;
    } gate_set_t;

endpackage

// File: rtl/chop_span_timer.sv
module chop_span_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic [CW-1:0] limit_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = restart_i ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == limit_i - CW'(1));
endmodule

// File: rtl/chop_blanker.sv
module chop_blanker #(
    parameter int BLANK_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic active_o
);
    localparam int BW = $clog2(BLANK_CYC + 1);

    logic [BW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (load_i)              left_d = BW'(BLANK_CYC);
        else if (left_q != '0)   left_d = left_q - BW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign active_o = (left_q != '0);
endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
    import chop_pkg::*;
(
    input  chop_state_e state_i,
    input  logic        dir_i,
    input  logic        rect_i,
    output gate_set_t   gates_o
);
    always_comb begin
        gates_o = '0;
        case (state_i)
            ST_DRIVE: begin
                gates_o.hs_a = dir_i;
                gates_o.ls_b = dir_i;
                gates_o.hs_b = !dir_i;
                gates_o.ls_a = !dir_i;
            end
            ST_FAST: begin
                gates_o.hs_b = rect_i && dir_i;
                gates_o.ls_a = rect_i && dir_i;
                gates_o.hs_a = rect_i && !dir_i;
                gates_o.ls_b = rect_i && !dir_i;
            end
            ST_SLOW: begin
                gates_o.ls_a = rect_i;
                gates_o.ls_b = rect_i;
            end
            default: gates_o = '0;
        endcase
    end
endmodule

// File: rtl/mixdecay_chopper.sv
module mixdecay_chopper
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 7500,
    parameter int BLANK_CYC = 250,
    parameter int DEAD_CYC  = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       phase_i,
    input  logic       cmp_i,
    input  logic       zero_i,
    output logic       hs_a_o,
    output logic       hs_b_o,
    output logic       ls_a_o,
    output logic       ls_b_o,
    output logic [2:0] state_o
);
    localparam int FAST_CYC = (OFF_CYC * 301 + 500) / 1000;
    localparam int SLOW_CYC = OFF_CYC - FAST_CYC - DEAD_CYC;
    localparam int CW       = $clog2(OFF_CYC + 1);

    chop_regs_t    q, d;
    logic          blank_act, span_last, span_restart, blank_load;
    logic [CW-1:0] span_limit;
    gate_set_t     gates;

    always_comb begin
        case (q.state)
            ST_FAST: span_limit = CW'(FAST_CYC);
            ST_GAP:  span_limit = CW'(DEAD_CYC);
            ST_SLOW: span_limit = CW'(SLOW_CYC);
            default: span_limit = CW'(OFF_CYC);
        endcase
    end

    always_comb begin
        d = q;
        if (!en_i) begin
            d.state = ST_COAST;
            d.rect  = 1'b1;
        end else begin
            case (q.state)
                ST_COAST: begin
                    d.state = ST_DRIVE;
                    d.dir   = phase_i;
                end
                ST_DRIVE: begin
                    if (cmp_i && !blank_act) begin
                        d.state = ST_FAST;
                        d.rect  = 1'b1;
                    end
                end
                ST_FAST: begin
                    if (zero_i)    d.rect  = 1'b0;
                    if (span_last) d.state = ST_GAP;
                end
                ST_GAP: begin
                    if (zero_i)    d.rect  = 1'b0;
                    if (span_last) d.state = ST_SLOW;
                end
                ST_SLOW: begin
                    if (zero_i) d.rect = 1'b0;
                    if (span_last) begin
                        d.state = ST_DRIVE;
                        d.dir   = phase_i;
                    end
                end
                default: d.state = ST_COAST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_COAST, dir: 1'b1, rect: 1'b1};
        else        q <= d;
    end

    assign span_restart = (d.state != q.state);
    assign blank_load   = (d.state == ST_DRIVE) && (q.state != ST_DRIVE);

    chop_span_timer #(.CW(CW)) i_span (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (span_restart),
        .limit_i   (span_limit),
        .last_o    (span_last)
    );

    chop_blanker #(.BLANK_CYC(BLANK_CYC)) i_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (blank_load),
        .active_o (blank_act)
    );

    chop_gate_map i_map (
        .state_i (q.state),
        .dir_i   (q.dir),
        .rect_i  (q.rect),
        .gates_o (gates)
    );

    assign hs_a_o  = gates.hs_a;
    assign hs_b_o  = gates.hs_b;
    assign ls_a_o  = gates.ls_a;
    assign ls_b_o  = gates.ls_b;
    assign state_o = q.state;

    AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a_o && ls_a_o)); // R9
    AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_b_o && ls_b_o)); // R9
    AST_COAST_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_o == 3'd0 && gates == '0)); // R1
    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && q.state == ST_DRIVE && blank_act) |=> q.state == ST_DRIVE); // R3
    AST_TRIP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && q.state == ST_DRIVE && !blank_act && cmp_i) |=> q.state == ST_FAST); // R4
    AST_FAST_TO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && q.state == ST_FAST && span_last) |=> q.state == ST_GAP); // R5
    AST_GAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        q.state == ST_GAP |-> gates == '0); // R5
    AST_RECT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && zero_i && (q.state == ST_FAST || q.state == ST_GAP || q.state == ST_SLOW)
         && d.state != ST_DRIVE) |=> gates == '0); // R7
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_FAST || q.state == ST_GAP) |=> $stable(q.dir)); // R2
endmodule

// File: tb/test_mixdecay_chopper.sv
module test_mixdecay_chopper;
    localparam int OFF   = 40;
    localparam int BLNK  = 5;
    localparam int DEAD  = 3;
    localparam int FASTE = 12;   // round(0.301 * 40)

    localparam logic [2:0] S_COAST = 3'd0, S_ON = 3'd1, S_FAST = 3'd2,
                           S_GAP = 3'd3, S_SLOW = 3'd4;
    // gate vector order {hs_a, hs_b, ls_a, ls_b}
    localparam logic [3:0] G_OFF = 4'b0000, G_FWD = 4'b1001,
                           G_REV = 4'b0110, G_LOW = 4'b0011;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en_i = 1'b0, phase_i = 1'b0, cmp_i = 1'b0, zero_i = 1'b0;
    logic hs_a_o, hs_b_o, ls_a_o, ls_b_o;
    logic [2:0] state_o;

    int cyc = 0, checks = 0, errors = 0, leg_bad = 0;
    bit done = 0;

    typedef struct {
        int         at;
        logic [2:0] st;
        logic [3:0] g;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mixdecay_chopper #(.OFF_CYC(OFF), .BLANK_CYC(BLNK), .DEAD_CYC(DEAD)) i_mixdecay_chopper (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .phase_i(phase_i),
        .cmp_i(cmp_i), .zero_i(zero_i),
        .hs_a_o(hs_a_o), .hs_b_o(hs_b_o), .ls_a_o(ls_a_o), .ls_b_o(ls_b_o),
        .state_o(state_o));

    task automatic expect_at(int at, logic [2:0] st, logic [3:0] g, string tag);
        exp_t e;
        e.at = at; e.st = st; e.g = g; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic go_to(int n);
        while (cyc < n) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if ((hs_a_o && ls_a_o) || (hs_b_o && ls_b_o)) leg_bad++;
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (e.at != cyc || state_o != e.st ||
                    {hs_a_o, hs_b_o, ls_a_o, ls_b_o} != e.g) begin
                    errors++;
                    $display("FAIL %s cyc %0d: state %0d gates %b, expected state %0d gates %b (due %0d)",
                             e.tag, cyc, state_o, {hs_a_o, hs_b_o, ls_a_o, ls_b_o}, e.st, e.g, e.at);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired at cyc %0d, expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        int t, u, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_at(cyc + 1, S_COAST, G_OFF, "R1");
        go_to(cyc + 2);

        // continuous trip, forward direction
        t = cyc;
        en_i = 1'b1; phase_i = 1'b1; cmp_i = 1'b1;
        expect_at(t + 1,  S_ON,   G_FWD, "R2");
        expect_at(t + 6,  S_ON,   G_FWD, "R3");
        expect_at(t + 7,  S_FAST, G_REV, "R4");
        expect_at(t + 18, S_FAST, G_REV, "R4");
        expect_at(t + 19, S_GAP,  G_OFF, "R5");
        expect_at(t + 21, S_GAP,  G_OFF, "R5");
        expect_at(t + 22, S_SLOW, G_LOW, "R6");
        expect_at(t + 30, S_SLOW, G_LOW, "R6");
        expect_at(t + 31, S_SLOW, G_OFF, "R7");
        expect_at(t + 46, S_SLOW, G_OFF, "R7");
        expect_at(t + 47, S_ON,   G_FWD, "R8");
        expect_at(t + 49, S_ON,   G_FWD, "R2");
        expect_at(t + 52, S_ON,   G_FWD, "R8");
        expect_at(t + 53, S_FAST, G_REV, "R2");
        expect_at(t + 55, S_FAST, G_REV, "R4");
        expect_at(t + 56, S_FAST, G_OFF, "R7");
        expect_at(t + 65, S_GAP,  G_OFF, "R5");
        expect_at(t + 68, S_SLOW, G_OFF, "R7");
        expect_at(t + 92, S_SLOW, G_OFF, "R6");
        expect_at(t + 93, S_ON,   G_REV, "R8");
        expect_at(t + 98, S_ON,   G_REV, "R3");
        expect_at(t + 99, S_FAST, G_FWD, "R4");
        expect_at(t + 101, S_COAST, G_OFF, "R1");
        go_to(t + 30);  zero_i = 1'b1;
        go_to(t + 31);  zero_i = 1'b0;
        go_to(t + 48);  phase_i = 1'b0;
        go_to(t + 55);  zero_i = 1'b1;
        go_to(t + 56);  zero_i = 1'b0;
        go_to(t + 100); en_i = 1'b0; cmp_i = 1'b0;

        // comparator pulse inside blanking, then late trip
        go_to(t + 104);
        u = cyc;
        en_i = 1'b1; phase_i = 1'b1; cmp_i = 1'b0;
        expect_at(u + 5,  S_ON,   G_FWD, "R3");
        expect_at(u + 20, S_ON,   G_FWD, "R3");
        expect_at(u + 21, S_FAST, G_REV, "R3");
        expect_at(u + 23, S_COAST, G_OFF, "R1");
        go_to(u + 3);  cmp_i = 1'b1;
        go_to(u + 4);  cmp_i = 1'b0;
        go_to(u + 20); cmp_i = 1'b1;
        go_to(u + 22); en_i = 1'b0; cmp_i = 1'b0;

        // reverse direction from coast
        go_to(u + 26);
        w = cyc;
        en_i = 1'b1; phase_i = 1'b0; cmp_i = 1'b1;
        expect_at(w + 1, S_ON,   G_REV, "R2");
        expect_at(w + 7, S_FAST, G_FWD, "R4");
        expect_at(w + 9, S_COAST, G_OFF, "R1");
        go_to(w + 8); en_i = 1'b0; cmp_i = 1'b0;

        go_to(w + 12);
        checks++;
        if (leg_bad != 0 || sb.size() != 0) begin
            errors++;
            $display("FAIL R9 leg overlaps %0d pending %0d, expected 0 and 0", leg_bad, sb.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule